// File: doc/BRIEF.md
# Link-Layer Frame Check Sequence Unit

This block keeps the 16-bit frame check sequence of a link-layer frame while the frame's bytes go through it, one byte per clock. On the transmit side, a clear pulse starts a frame and each valid byte is folded into the running register. A finish request then latches the two trailer bytes to append: the complemented low half first, then the complemented high half. On the receive side the same path is used. The incoming frame, including the two trailer bytes as they arrive, is fed through the register. The frame is good when the register ends on the fixed residue 0xF0B8.

The unit also counts accepted bytes. It refuses any data byte that would leave no room for the trailer within the maximum frame length. It flags frames that are still shorter than the minimum header length. Bit-level framing, bit stuffing and frame storage belong to neighbouring blocks.

Top module: `fcs16_unit`

## Requirements
- R1: After reset, `fcs_o` is 0xFFFF, `len_o` is 0, `trailer_vld_o` is 0, `crc_ok_o` is 0 and both trailer bytes are 0x00.
- R2: A cycle with `start_i` high sets `fcs_o` to 0xFFFF, `len_o` to 0 and `trailer_vld_o` to 0 on the next clock.
- R3: An accepted byte d updates the register, visible on the next clock, as follows. Let e = fcs[7:0] ^ d and f = e ^ (e << 4), both truncated to 8 bits. The new value is (fcs >> 8) ^ (f << 8) ^ (f << 3) ^ (f >> 4). Over the ASCII bytes "123456789" the register ends at 0x6F91.
- R4: Each accepted byte raises `len_o` by one on the next clock.
- R5: A byte with `byte_vld_i` high is refused when `len_o` is already at least MAX_LEN-4 (326 by default). In that cycle `byte_rej_o` is 1, and `fcs_o` and `len_o` stay unchanged.
- R6: `finish_i` without `start_i` sets `trailer_vld_o` on the next clock. The same clock latches `tx_lo_o` = ~fcs[7:0] and `tx_hi_o` = ~fcs[15:8] from the register as it was in the finish cycle; `tx_lo_o` is transmitted first. A byte presented in the same cycle as `finish_i` is dropped.
- R7: `crc_ok_o` is 1 exactly when the register equals 0xF0B8. This happens after the data and its correct trailer bytes have been fed in, and not when a data byte is corrupted.
- R8: `hdr_short_o` is 1 while `len_o` is below MIN_HDR (17 by default).
- R9: `start_i` takes priority: a byte or finish request in the same cycle has no effect beyond the clear.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | Clear pulse at frame start |
| byte_vld_i | input | 1 | Data byte strobe |
| byte_i | input | 8 | Data byte |
| finish_i | input | 1 | Latch the trailer bytes |
| fcs_o | output | 16 | Running check register |
| len_o | output | 9 | Accepted byte count |
| byte_rej_o | output | 1 | Byte refused in this cycle (length cap) |
| tx_lo_o | output | 8 | First trailer byte to send |
| tx_hi_o | output | 8 | Second trailer byte to send |
| trailer_vld_o | output | 1 | Trailer bytes valid |
| crc_ok_o | output | 1 | Register equals the good residue |
| hdr_short_o | output | 1 | Frame shorter than minimum header |

## Verification
The hardest state to reach from the ports is the length cap. A refusal only happens after 326 bytes have been accepted into one frame. The stimulus therefore streams filler bytes in a loop until `len_o` reaches the limit, and then offers one more byte. The bench checks that this byte is flagged and that neither the register nor the count moves. The receive check depends on the trailer the unit itself produced, so the bench feeds that trailer back into a fresh frame and expects the residue.

// File: rtl/fcs16_pkg.sv
package fcs16_pkg;

  localparam logic [15:0] FCS_INIT    = 16'hFFFF;
  localparam logic [15:0] FCS_RESIDUE = 16'hF0B8;

  // One byte of the reflected CRC-16 in shift/XOR form.
  function automatic logic [15:0] fcs_step(input logic [15:0] c, input logic [7:0] d);
    logic [7:0] e;
    logic [7:0] f;
    e = c[7:0] ^ d;
    f = e ^ (e << 4);
    return {8'h00, c[15:8]} ^ {f, 8'h00} ^ ({8'h00, f} << 3) ^ ({8'h00, f} >> 4);
  endfunction

endpackage

// File: rtl/fcs16_accum.sv
module fcs16_accum
  import fcs16_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  logic        clr,
  input  logic        take,
  input  logic [7:0]  data,
  output logic [15:0] fcs_q
);
  logic [15:0] fcs_next;

  assign fcs_next = fcs_step(fcs_q, data);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    fcs_q <= FCS_INIT;
    else if (clr)  fcs_q <= FCS_INIT;
    else if (take) fcs_q <= fcs_next;
  end
endmodule

// File: rtl/fcs16_len_ctr.sv
module fcs16_len_ctr #(
  parameter int MAX_LEN  = 330,
  parameter int FCS_ROOM = 4,
  parameter int MIN_HDR  = 17,
  parameter int LW       = $clog2(MAX_LEN + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          clr,
  input  logic          inc,
  output logic [LW-1:0] len_q,
  output logic          room,
  output logic          short_hdr
);
  localparam int LIMIT = MAX_LEN - FCS_ROOM;
  localparam logic [LW-1:0] LIMIT_V = LW'(LIMIT);
  localparam logic [LW-1:0] MINH_V  = LW'(MIN_HDR);

  assign room      = (len_q < LIMIT_V);
  assign short_hdr = (len_q < MINH_V);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)   len_q <= '0;
    else if (clr) len_q <= '0;
    else if (inc) len_q <= len_q + LW'(1);
  end
endmodule

// File: rtl/fcs16_trailer.sv
module fcs16_trailer (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        clr,
  input  logic        cap,
  input  logic [15:0] fcs_in,
  output logic [7:0]  lo_q,
  output logic [7:0]  hi_q,
  output logic        vld_q
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      lo_q  <= 8'h00;
      hi_q  <= 8'h00;
      vld_q <= 1'b0;
    end else if (clr) begin
      vld_q <= 1'b0;
    end else if (cap) begin
      lo_q  <= ~fcs_in[7:0];
      hi_q  <= ~fcs_in[15:8];
      vld_q <= 1'b1;
    end
  end
endmodule

// File: rtl/fcs16_unit.sv
module fcs16_unit
  import fcs16_pkg::*;
#(
  parameter int MAX_LEN  = 330,
  parameter int FCS_ROOM = 4,
  parameter int MIN_HDR  = 17,
  parameter int LW       = $clog2(MAX_LEN + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start_i,
  input  logic          byte_vld_i,
  input  logic [7:0]    byte_i,
  input  logic          finish_i,
  output logic [15:0]   fcs_o,
  output logic [LW-1:0] len_o,
  output logic          byte_rej_o,
  output logic [7:0]    tx_lo_o,
  output logic [7:0]    tx_hi_o,
  output logic          trailer_vld_o,
  output logic          crc_ok_o,
  output logic          hdr_short_o
);
  // Named internal events
  logic byte_offer_w;
  logic byte_take_w;
  logic finish_cap_w;
  logic room_w;

  assign byte_offer_w = byte_vld_i && !start_i && !finish_i;
  assign byte_take_w  = byte_offer_w && room_w;
  assign byte_rej_o   = byte_vld_i && !start_i && !finish_i && !room_w;
  assign finish_cap_w = finish_i && !start_i;

  fcs16_accum u_accum (
    .clk   (clk),
    .rst_n (rst_n),
    .clr   (start_i),
    .take  (byte_take_w),
    .data  (byte_i),
    .fcs_q (fcs_o)
  );

  fcs16_len_ctr #(
    .MAX_LEN  (MAX_LEN),
    .FCS_ROOM (FCS_ROOM),
    .MIN_HDR  (MIN_HDR),
    .LW       (LW)
  ) u_len (
    .clk       (clk),
    .rst_n     (rst_n),
    .clr       (start_i),
    .inc       (byte_take_w),
    .len_q     (len_o),
    .room      (room_w),
    .short_hdr (hdr_short_o)
  );

  fcs16_trailer u_trl (
    .clk    (clk),
    .rst_n  (rst_n),
    .clr    (start_i),
    .cap    (finish_cap_w),
    .fcs_in (fcs_o),
    .lo_q   (tx_lo_o),
    .hi_q   (tx_hi_o),
    .vld_q  (trailer_vld_o)
  );

  assign crc_ok_o = (fcs_o == FCS_RESIDUE);
endmodule

// File: rtl/fcs16_unit_chk.sv
module fcs16_unit_chk
  import fcs16_pkg::*;
#(
  parameter int MAX_LEN  = 330,
  parameter int FCS_ROOM = 4,
  parameter int LW       = $clog2(MAX_LEN + 1)
) (
  input logic          clk,
  input logic          rst_n,
  input logic          start_i,
  input logic          finish_i,
  input logic          byte_vld_i,
  input logic [7:0]    byte_i,
  input logic [15:0]   fcs_o,
  input logic [LW-1:0] len_o,
  input logic          byte_take_w,
  input logic          byte_rej_o,
  input logic          trailer_vld_o,
  input logic [7:0]    tx_lo_o,
  input logic [7:0]    tx_hi_o
);
  localparam logic [LW-1:0] CAP_V = LW'(MAX_LEN - FCS_ROOM);

  p_start_clears_r2: assert property (@(posedge clk) disable iff (!rst_n)
    start_i |=> (fcs_o == FCS_INIT) && (len_o == '0) && !trailer_vld_o);

  p_byte_update_r3: assert property (@(posedge clk) disable iff (!rst_n)
    byte_take_w |=> fcs_o == fcs_step($past(fcs_o), $past(byte_i)));

  p_len_step_r4: assert property (@(posedge clk) disable iff (!rst_n)
    byte_take_w |=> len_o == $past(len_o) + LW'(1));

  p_reject_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
    byte_rej_o |=> $stable(fcs_o) && $stable(len_o));

  p_no_overflow_r5: assert property (@(posedge clk) disable iff (!rst_n)
    len_o <= CAP_V);

  p_trailer_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (finish_i && !start_i) |=> trailer_vld_o && (tx_lo_o == ~$past(fcs_o[7:0]))
                              && (tx_hi_o == ~$past(fcs_o[15:8])));

  p_start_wins_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (start_i && byte_vld_i) |=> len_o == '0);
endmodule

bind fcs16_unit fcs16_unit_chk #(
  .MAX_LEN  (MAX_LEN),
  .FCS_ROOM (FCS_ROOM),
  .LW       (LW)
) u_chk (
  .clk           (clk),
  .rst_n         (rst_n),
  .start_i       (start_i),
  .finish_i      (finish_i),
  .byte_vld_i    (byte_vld_i),
  .byte_i        (byte_i),
  .fcs_o         (fcs_o),
  .len_o         (len_o),
  .byte_take_w   (byte_take_w),
  .byte_rej_o    (byte_rej_o),
  .trailer_vld_o (trailer_vld_o),
  .tx_lo_o       (tx_lo_o),
  .tx_hi_o       (tx_hi_o)
);

// File: tb/fcs16_unit_tb.sv
`timescale 1ns/1ps
module fcs16_unit_tb;
  localparam int LW = 9;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          start_i = 1'b0;
  logic          byte_vld_i = 1'b0;
  logic [7:0]    byte_i = 8'h00;
  logic          finish_i = 1'b0;
  logic [15:0]   fcs_o;
  logic [LW-1:0] len_o;
  logic          byte_rej_o;
  logic [7:0]    tx_lo_o, tx_hi_o;
  logic          trailer_vld_o, crc_ok_o, hdr_short_o;

  int checks = 0;
  int errors = 0;
  logic rej_seen;
  logic [15:0] model;
  bit done = 0;

  always #4 clk = ~clk;

  fcs16_unit u_dut (.*);

  // Stimulus table: the nine check bytes, with the expected register after the last.
  localparam logic [7:0] VEC [9] = '{8'h31, 8'h32, 8'h33, 8'h34, 8'h35,
                                     8'h36, 8'h37, 8'h38, 8'h39};
  localparam logic [15:0] VEC_FINAL = 16'h6F91;

  // Bit-serial reference with the reversed polynomial.
  function automatic logic [15:0] ref_step(input logic [15:0] c, input logic [7:0] d);
    for (int i = 0; i < 8; i++) begin
      if ((c[0] ^ d[i]) == 1'b1) c = (c >> 1) ^ 16'h8408;
      else                       c = c >> 1;
    end
    return c;
  endfunction

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic drive(input logic s, input logic v, input logic [7:0] b, input logic f);
    @(negedge clk);
    start_i = s; byte_vld_i = v; byte_i = b; finish_i = f;
    #1 rej_seen = byte_rej_o;
    @(posedge clk); #1;
    start_i = 0; byte_vld_i = 0; finish_i = 0;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    #1;
    // R1 reset state
    check("R1 fcs", fcs_o, 16'hFFFF);
    check("R1 len", len_o, 0);
    check("R1 vld", trailer_vld_o, 0);
    check("R1 ok", crc_ok_o, 0);
    check("R1 lo", tx_lo_o, 0);
    check("R8 short at reset", hdr_short_o, 1);
    @(negedge clk) rst_n = 1'b1;

    // R2 clear, then R3/R4 table walk
    drive(1, 0, 0, 0);
    check("R2 fcs", fcs_o, 16'hFFFF);
    model = 16'hFFFF;
    for (int i = 0; i < 9; i++) begin
      drive(0, 1, VEC[i], 0);
      model = ref_step(model, VEC[i]);
      check("R3 step", fcs_o, model);
      check("R4 len", len_o, i + 1);
    end
    check("R3 final", fcs_o, VEC_FINAL);

    // R6 trailer
    drive(0, 0, 0, 1);
    check("R6 vld", trailer_vld_o, 1);
    check("R6 lo", tx_lo_o, 8'h6E);
    check("R6 hi", tx_hi_o, 8'h90);
    drive(1, 0, 0, 0);
    check("R2 vld cleared", trailer_vld_o, 0);

    // R7 receive with good trailer
    for (int i = 0; i < 9; i++) drive(0, 1, VEC[i], 0);
    drive(0, 1, 8'h6E, 0);
    check("R7 ok before last", crc_ok_o, 0);
    drive(0, 1, 8'h90, 0);
    check("R7 ok good", crc_ok_o, 1);

    // R7 corrupted byte
    drive(1, 0, 0, 0);
    for (int i = 0; i < 9; i++) drive(0, 1, (i == 4) ? 8'h75 : VEC[i], 0);
    drive(0, 1, 8'h6E, 0);
    drive(0, 1, 8'h90, 0);
    check("R7 ok bad", crc_ok_o, 0);

    // R8 header length, R5 length cap
    drive(1, 0, 0, 0);
    for (int i = 0; i < 16; i++) drive(0, 1, 8'(i), 0);
    check("R8 short 16", hdr_short_o, 1);
    drive(0, 1, 8'hA5, 0);
    check("R8 short 17", hdr_short_o, 0);
    for (int i = 17; i < 326; i++) drive(0, 1, 8'(i * 7), 0);
    check("R5 len at cap", len_o, 326);
    model = fcs_o;
    drive(0, 1, 8'h5A, 0);
    check("R5 rej flag", rej_seen, 1);
    check("R5 fcs held", fcs_o, model);
    check("R5 len held", len_o, 326);

    // R9 start wins over byte and finish
    drive(1, 1, 8'h12, 1);
    check("R9 fcs", fcs_o, 16'hFFFF);
    check("R9 len", len_o, 0);
    check("R9 vld", trailer_vld_o, 0);

    // R6 finish with byte: byte dropped; empty frame trailer is 00 00
    drive(0, 1, 8'h33, 1);
    check("R6 byte dropped len", len_o, 0);
    check("R6 byte dropped fcs", fcs_o, 16'hFFFF);
    check("R6 empty lo", tx_lo_o, 8'h00);
    check("R6 empty hi", tx_hi_o, 8'h00);
    check("R6 empty vld", trailer_vld_o, 1);

    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule